// File: doc/BRIEF.md
# Fractional-Baud Variable-Length UART Transmitter

This block sends asynchronous serial characters of 1 to 32 data bits. The bits go out least significant first, after a low start bit and before a high stop bit. The line rests high between characters. Bit timing comes from one 16-bit rate word, whose top bit picks one of two timing engines. With the top bit clear, the lower fifteen bits are a whole number of system clocks per bit, and every bit has exactly that length. With the top bit set, the lower fifteen bits are added each clock into a 15-bit phase accumulator. Each carry out of that accumulator closes a bit, which gives fractional rates.

The accumulator is cleared when each character is accepted. A fractional setting therefore gives the same sequence of bit lengths in every frame, and no jitter builds up from one character to the next. Every line transition falls on a system-clock edge.

A word enters through a valid/ready handshake, which completes only while the transmitter is idle. The rate and length settings are captured at that moment and held for the whole frame. A busy flag covers the frame from the start bit through the end of the stop bit.

The frame controller has four states:
- `ST_IDLE`: moves to `ST_START` on an accepted word.
- `ST_START`: moves to `ST_DATA` at the end of a bit period.
- `ST_DATA`: moves to `ST_STOP` at the end of the last data bit's period.
- `ST_STOP`: moves back to `ST_IDLE` at the end of its bit period.

Top module: `frac_baud_uart_tx`

## Requirements
- R1: The line idles high. A frame is one low start bit, then the data bits with bit 0 first, then one high stop bit.
- R2: When rate word bit 15 is 0, each bit (start, data and stop) lasts exactly rate[14:0] system clocks.
- R3: In integer mode, a rate[14:0] of 0 or 1 is treated as 2, so every bit lasts at least two clocks.
- R4: When rate word bit 15 is 1, the addend A is rate[14:0]. Bit boundary k (k=1 at the end of the start bit) falls ceil(k*32768/A) clocks after the accepting clock edge.
- R5: The phase accumulator is cleared on every accepted word, so repeated frames with the same fractional setting produce identical waveforms.
- R6: The length field holds the data bit count minus one: 0 sends 1 bit and 31 sends 32 bits.
- R7: in_ready is high only when idle. A word is taken on a clock edge where in_valid and in_ready are both high. busy rises after that edge and falls at the end of the stop bit.
- R8: In fractional mode with an addend of 0, in_ready stays low, nothing is sent and the line stays high.
- R9: A change to the rate or length inputs during a frame has no effect on that frame. It applies from the next accepted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rate | input | 16 | Rate word: bit 15 selects fractional mode, bits 14..0 hold the count or the addend |
| cfg_len | input | 5 | Data bit count minus one |
| in_data | input | 32 | Character to send, bit 0 first |
| in_valid | input | 1 | in_data holds a word to send |
| in_ready | output | 1 | Transmitter can accept a word this cycle |
| busy | output | 1 | A frame is in progress |
| txd | output | 1 | Serial line output |

## Verification
The assertions check, on every cycle:
- the line is high whenever no frame is in progress;
- the line is low on the first cycle of a frame;
- the integer counter stays inside its period;
- no bit ends on the first clock of a frame;
- the bit index stays within the latched length;
- the latched rate holds still during a frame;
- a zero addend is never offered.

The bench covers what a property cannot. It compares the exact waveform, sample by sample, against boundaries computed from the rate word. It repeats fractional frames to show they are identical. It changes the inputs mid-frame and confirms the change only applies to the next frame. It drives the one-bit and 32-bit length extremes and integer counts of 0 and 1.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_e;
endpackage

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
    parameter int RATE_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic              nco_mode,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] acc_q;
    logic [RATE_W-1:0] lim;
    logic [RATE_W:0]   sum;

    // Integer period with a floor of two clocks.
    assign lim  = (rate < RATE_W'(2)) ? RATE_W'(2) : rate;
    assign sum  = {1'b0, acc_q} + {1'b0, rate};
    assign tick = run && (nco_mode ? sum[RATE_W] : (cnt_q == lim - RATE_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (run) begin
            if (nco_mode) begin
                acc_q <= sum[RATE_W-1:0];
            end else begin
                cnt_q <= tick ? '0 : cnt_q + RATE_W'(1);
            end
        end
    end

    assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !nco_mode) |-> (cnt_q < lim));

    assert_no_tick_after_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart) |-> !tick);
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len,
    output logic              bit_out,
    output logic              last
);
    logic [DATA_W-1:0] sh_q;
    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;

    assign bit_out = sh_q[0];
    assign last    = (idx_q == len_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
            len_q <= '0;
        end else if (load) begin
            sh_q  <= data;
            idx_q <= '0;
            len_q <= len;
        end else if (shift && !last) begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + LEN_W'(1);
        end
    end

    assert_idx_within_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= len_q);
endmodule

// File: rtl/frac_baud_uart_tx.sv
module frac_baud_uart_tx
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W),
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BAUD_W-1:0] cfg_rate,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              busy,
    output logic              txd
);
    localparam int RATE_W = BAUD_W - 1;

    tx_state_e         state_q, state_d;
    logic [BAUD_W-1:0] rate_q;
    logic              accept;
    logic              tick;
    logic              bit_out;
    logic              last;
    logic              zero_addend;

    assign zero_addend = cfg_rate[BAUD_W-1] && (cfg_rate[RATE_W-1:0] == '0);
    assign accept      = in_valid && in_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rate_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) rate_q <= cfg_rate;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)        state_d = ST_START;
            ST_START: if (tick)          state_d = ST_DATA;
            ST_DATA:  if (tick && last)  state_d = ST_STOP;
            ST_STOP:  if (tick)          state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready = 1'b0;
        busy     = 1'b1;
        txd      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = !zero_addend;
                busy     = 1'b0;
            end
            ST_START: txd = 1'b0;
            ST_DATA:  txd = bit_out;
            ST_STOP:  txd = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    uart_bit_timer #(.RATE_W(RATE_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .run      (state_q != ST_IDLE),
        .nco_mode (rate_q[BAUD_W-1]),
        .rate     (rate_q[RATE_W-1:0]),
        .tick     (tick)
    );

    uart_tx_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .shift   (state_q == ST_DATA && tick),
        .data    (in_data),
        .len     (cfg_len),
        .bit_out (bit_out),
        .last    (last)
    );

    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    assert_rate_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rate_q));

    assert_zero_addend_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_addend |-> !in_ready);

    assert_ready_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !busy);
endmodule

// File: tb/test_frac_baud_uart_tx.sv
module test_frac_baud_uart_tx;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_rate = 16'd4;
    logic [4:0]  cfg_len = 5'd7;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready, busy, txd;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    frac_baud_uart_tx i_frac_baud_uart_tx (
        .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_len(cfg_len),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .busy(busy), .txd(txd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Clocks from the accepting edge to bit boundary k (R2, R3, R4).
    function automatic longint bound(input int k, input logic [15:0] r);
        longint a, c;
        if (r[15]) begin
            a = longint'(r[14:0]);
            return (longint'(k) * 32768 + a - 1) / a;
        end
        c = (r[14:0] < 2) ? 2 : longint'(r[14:0]);
        return longint'(k) * c;
    endfunction

    // Sends one frame and checks every sample. perturb changes inputs mid-frame (R9).
    task automatic send(input logic [31:0] d, input logic [4:0] l, input logic [15:0] r,
                        input bit perturb, input string req, output logic [2047:0] wave);
        int nbits, total, seg, errs;
        logic exp_bit;
        nbits = int'(l) + 1;
        wave = '0;
        @(negedge clk);
        cfg_rate = r; cfg_len = l; in_data = d; in_valid = 1'b1;
        check({req, " R7 ready when idle"}, in_ready, 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (perturb) begin
            cfg_rate = {1'b0, 15'(($urandom % 7) + 3)};
            cfg_len  = 5'($urandom);
            in_data  = $urandom;
        end
        total = int'(bound(nbits + 2, r));
        errs = 0;
        seg = 0;
        for (int i = 1; i <= total + 1; i++) begin
            while (seg < nbits + 2 && longint'(i) > bound(seg + 1, r)) seg++;
            if (seg == 0) exp_bit = 1'b0;
            else if (seg <= nbits) exp_bit = d[seg-1];
            else exp_bit = 1'b1;
            if (i <= 2048) wave[i-1] = txd;
            if (txd !== exp_bit || busy !== (i <= total) || (busy && in_ready)) begin
                if (errs == 0)
                    $display("FAIL %s R1/R7 sample %0d: actual txd=%0b busy=%0b expected txd=%0b busy=%0b",
                             req, i, txd, busy, exp_bit, (i <= total));
                errs++;
            end
            @(negedge clk);
        end
        n_chk++;
        if (errs != 0) n_bad++;
    endtask

    initial begin
        logic [2047:0] w1, w2;
        logic [15:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("reset txd high R1", txd, 1);
        check("reset busy low R7", busy, 0);
        check("reset ready high R7", in_ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send(32'hA5, 5'd7, 16'd4, 0, "integer 8-bit R2", w1);
        send(32'h1, 5'd0, 16'd5, 0, "one data bit R6", w1);
        send(32'h0, 5'd0, 16'd3, 0, "one zero bit R6", w1);
        send(32'hDEADBEEF, 5'd31, 16'd3, 0, "32-bit word R6", w1);
        send(32'h5A, 5'd7, 16'd0, 0, "count 0 as 2 R3", w1);
        send(32'h3C, 5'd7, 16'd1, 0, "count 1 as 2 R3", w1);
        send(32'h96, 5'd7, 16'h8000 | 16'h4000, 0, "addend half R4", w1);
        send(32'h69, 5'd7, 16'h8000 | 16'h7FFF, 0, "addend max R4", w1);

        // R5: identical waveform for two frames at a fractional rate.
        send(32'hC3, 5'd9, 16'h8000 | 16'h5555, 0, "fractional frame A R4", w1);
        send(32'hC3, 5'd9, 16'h8000 | 16'h5555, 0, "fractional frame B R4", w2);
        check("repeat frames identical R5", (w1 == w2), 1);

        // R9: inputs changed during the frame do not alter it.
        send(32'h0F0F, 5'd15, 16'h8000 | 16'h2345, 1, "mid-frame change R9", w1);
        send(32'h0F0F, 5'd15, 16'h8000 | 16'h2345, 0, "next frame R9", w2);
        check("new config applied only next frame R9", (w1 == w2), 1);

        // R8: zero addend is refused and the line stays high.
        @(negedge clk);
        cfg_rate = 16'h8000; in_valid = 1'b1;
        begin
            int bad8;
            bad8 = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (in_ready !== 1'b0 || txd !== 1'b1 || busy !== 1'b0) bad8++;
            end
            check("zero addend sends nothing R8", bad8, 0);
        end
        in_valid = 1'b0;
        cfg_rate = 16'd4;
        @(negedge clk);
        check("ready back after zero addend R7", in_ready, 1);

        // Random frames in both modes.
        for (int n = 0; n < 40; n++) begin
            if ($urandom % 2) r = {1'b1, 15'(($urandom % 30000) + 1500)};
            else r = {1'b0, 15'($urandom % 24)};
            send($urandom, 5'($urandom), r, ($urandom % 3) == 0, "random frame R2 R4", w1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule